// File: doc/BRIEF.md
# Row Midpoint Generator

The block takes one binary row of edge pixels and marks the position of the midpoint of every pair of set pixels in that row. The row is copied into two shift registers that then slide past each other in opposite directions, one cell per clock. AND gates at aligned and adjacent cells catch each pair at the moment its two pixels meet.

Midpoints are reported with half-pixel resolution. Slot `m` of the result vector stands for the midpoint `m/2`, so a pair of pixels at columns `i` and `j` lands in slot `i+j`. A run is started by a parallel row load. The result is valid when the one-cycle done pulse arrives, and it stays unchanged until the next load. Accumulating midpoint counts over many rows and choosing a symmetry axis belong to a downstream block.

Top module: `row_midpoint_gen`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `done_o` and `mid_o` are all 0.
- R2: A `start_i` high at a clock edge while `busy_o` is low captures `row_i`. `busy_o` is high from the next cycle on, for exactly STEPS+1 consecutive cycles, where STEPS = ceil(NPIX/2).
- R3: `done_o` is high for exactly one cycle. That cycle is the first cycle after a run in which `busy_o` is low, and `done_o` is never high together with `busy_o`.
- R4: At `done_o`, bit m of `mid_o` (m = 0 .. 2*NPIX-2) is 1 exactly when some pixels i < j of the captured row are both 1 and satisfy i + j = m. Bit m = i + j covers both even and odd pair distances, including adjacent pixels and the two end pixels.
- R5: A pixel is never paired with itself. A row with zero or one set pixel gives `mid_o` = 0.
- R6: `mid_o` reads 0 in the first busy cycle of every run, whatever the previous result was.
- R7: `start_i` while `busy_o` is high is ignored. The run in progress keeps its timing and gives the result of the row it captured.
- R8: Outside a run, `mid_o` keeps its value until the next accepted start, whatever happens on `row_i`.
- R9: During a run, a bit of `mid_o` that has been set is never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load `row_i` and begin a run (ignored while busy) |
| row_i | input | NPIX | Edge pixels of one row, bit k = column k |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the result is final |
| mid_o | output | 2*NPIX-1 | Sticky midpoint vector, bit m = midpoint at column m/2 |

## Verification
With the start edge counted as edge 0, `busy_o` and the cleared `mid_o` are due just after edge 0. `busy_o` stays high through edge STEPS. The final `mid_o`, the falling `busy_o` and the `done_o` pulse all appear after edge STEPS+1, and `done_o` drops after edge STEPS+2. The bench drives its inputs on falling edges and samples on falling edges at each of these counted points. For every row it compares `mid_o` against an independent pairwise model that lists each i<j pair and sets slot i+j. Ignored starts and changes on `row_i` between runs are checked at the outputs: the bench looks at the result and the pulse timing of the run in progress, or at the held vector.

// File: rtl/rmg_pkg.sv
package rmg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  function automatic int half_up(int n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/rmg_shift_pair.sv
// Two copies of the row: a_q slides toward bit 0, b_q toward bit NPIX-1.
module rmg_shift_pair #(
  parameter int NPIX = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [NPIX-1:0] row_i,
  output logic [NPIX-1:0] a_o,
  output logic [NPIX-1:0] b_o
);
  logic [NPIX-1:0] a_q, b_q;

  for (genvar k = 0; k < NPIX; k++) begin : g_cell
    logic a_in, b_in;
    if (k == NPIX - 1) begin : g_a_edge
      assign a_in = 1'b0;
    end else begin : g_a_mid
      assign a_in = a_q[k+1];
    end
    if (k == 0) begin : g_b_edge
      assign b_in = 1'b0;
    end else begin : g_b_mid
      assign b_in = b_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q[k] <= 1'b0;
        b_q[k] <= 1'b0;
      end else if (load_i) begin
        a_q[k] <= row_i[k];
        b_q[k] <= row_i[k];
      end else if (shift_i) begin
        a_q[k] <= a_in;
        b_q[k] <= b_in;
      end
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;
endmodule

// File: rtl/rmg_pair_and.sv
// Aligned cells hit whole-pixel slots, adjacent cells hit half-pixel slots.
module rmg_pair_and #(
  parameter int NPIX = 16,
  localparam int NSLOT = 2 * NPIX - 1
) (
  input  logic             first_i,
  input  logic [NPIX-1:0]  a_i,
  input  logic [NPIX-1:0]  b_i,
  output logic [NSLOT-1:0] hit_o
);
  for (genvar k = 0; k < NPIX; k++) begin : g_even
    // at zero shift the aligned compare is a pixel with itself
    assign hit_o[2*k] = a_i[k] & b_i[k] & ~first_i;
  end
  for (genvar k = 0; k < NPIX - 1; k++) begin : g_odd
    assign hit_o[2*k+1] = a_i[k] & b_i[k+1];
  end
endmodule

// File: rtl/rmg_seq.sv
module rmg_seq
  import rmg_pkg::*;
#(
  parameter int NPIX = 16,
  localparam int STEPS = half_up(NPIX),
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic eval_o,
  output logic shift_o,
  output logic first_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic last;

  assign last    = (cnt_q == CW'(STEPS));
  assign load_o  = start_i && (state_q == ST_IDLE);
  assign eval_o  = (state_q == ST_RUN);
  assign shift_o = eval_o && !last;
  assign first_o = (cnt_q == '0);
  assign busy_o  = eval_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (eval_o) begin
        if (last) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_midpoint_gen.sv
module row_midpoint_gen #(
  parameter int NPIX = 16,
  localparam int NSLOT = 2 * NPIX - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NPIX-1:0]  row_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NSLOT-1:0] mid_o
);
  logic load, eval, shift, first;
  logic [NPIX-1:0] a_cells, b_cells;
  logic [NSLOT-1:0] hit, mid_q;

  rmg_seq #(.NPIX(NPIX)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .eval_o  (eval),
    .shift_o (shift),
    .first_o (first),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  rmg_shift_pair #(.NPIX(NPIX)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .row_i   (row_i),
    .a_o     (a_cells),
    .b_o     (b_cells)
  );

  rmg_pair_and #(.NPIX(NPIX)) u_and (
    .first_i (first),
    .a_i     (a_cells),
    .b_i     (b_cells),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mid_q <= '0;
    else if (load) mid_q <= '0;
    else if (eval) mid_q <= mid_q | hit;
  end

  assign mid_o = mid_q;
endmodule

// File: rtl/row_midpoint_gen_chk.sv
module row_midpoint_gen_chk
  import rmg_pkg::*;
#(
  parameter int NPIX = 16,
  localparam int NSLOT = 2 * NPIX - 1,
  localparam int STEPS = half_up(NPIX),
  localparam int CW = $clog2(STEPS + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [NSLOT-1:0] mid_o
);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!busy_o && !done_o && mid_o == '0);
    end
  end

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_busy_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(run_len) <= STEPS));
  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (int'($past(run_len)) == STEPS));
  assert_done_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_clear_on_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mid_o == '0));
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o) && !$past(start_i)) |-> $stable(mid_o));
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((mid_o & $past(mid_o)) == $past(mid_o)));
endmodule

bind row_midpoint_gen row_midpoint_gen_chk #(.NPIX(NPIX)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mid_o   (mid_o)
);

// File: tb/row_midpoint_gen_test.sv
`timescale 1ns/1ps
module row_midpoint_gen_test;
  localparam int NPIX = 16;
  localparam int NSLOT = 2 * NPIX - 1;
  localparam int STEPS = (NPIX + 1) / 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NPIX-1:0] row_i = '0;
  logic busy_o, done_o;
  logic [NSLOT-1:0] mid_o;

  int checks = 0;
  int fails = 0;

  row_midpoint_gen #(.NPIX(NPIX)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .row_i(row_i),
    .busy_o(busy_o), .done_o(done_o), .mid_o(mid_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [NSLOT-1:0] ref_mid(logic [NPIX-1:0] r);
    logic [NSLOT-1:0] m = '0;
    for (int i = 0; i < NPIX; i++)
      for (int j = i + 1; j < NPIX; j++)
        if (r[i] && r[j]) m[i+j] = 1'b1;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full run; if poke, a start with another row is applied mid-run
  task automatic run_row(input logic [NPIX-1:0] r, input bit poke, input string tag);
    logic [NSLOT-1:0] exp = ref_mid(r);
    @(negedge clk);
    start_i = 1'b1;
    row_i = r;
    @(negedge clk);
    start_i = 1'b0;
    row_i = ~r;
    check(busy_o === 1'b1, {"R2 busy after start ", tag}, 64'(busy_o), 64'd1);
    check(mid_o === '0, {"R6 cleared on load ", tag}, 64'(mid_o), 64'd0);
    for (int c = 1; c <= STEPS; c++) begin
      if (poke && c == 2) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o === 1'b1 && done_o === 1'b0, {"R2 busy window ", tag},
            64'({busy_o, done_o}), 64'b10);
    end
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b1, {"R3 done at end ", tag},
          64'({busy_o, done_o}), 64'b01);
    check(mid_o === exp, {poke ? "R7 busy start ignored " : "R4 midpoints ", tag},
          64'(mid_o), 64'(exp));
    @(negedge clk);
    check(done_o === 1'b0, {"R3 done one cycle ", tag}, 64'(done_o), 64'd0);
  endtask

  task automatic test_reset();
    check(busy_o === 1'b0 && done_o === 1'b0 && mid_o === '0, "R1 in reset",
          64'({busy_o, done_o, mid_o}), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && mid_o === '0, "R1 after release",
          64'({busy_o, done_o, mid_o}), 64'd0);
  endtask

  task automatic test_few_pixels();
    run_row('0, 1'b0, "empty");
    check(mid_o === '0, "R5 empty row", 64'(mid_o), 64'd0);
    run_row(16'h0100, 1'b0, "single");
    check(mid_o === '0, "R5 single pixel", 64'(mid_o), 64'd0);
    run_row(16'h0001, 1'b0, "single edge");
    check(mid_o === '0, "R5 single at bit 0", 64'(mid_o), 64'd0);
  endtask

  task automatic test_patterns();
    run_row(16'h0003, 1'b0, "adjacent low");
    check(mid_o === NSLOT'(1 << 1), "R4 slot 1", 64'(mid_o), 64'h2);
    run_row(16'h8001, 1'b0, "ends");
    check(mid_o === NSLOT'(1 << (NPIX - 1)), "R4 end pair slot", 64'(mid_o),
          64'(1 << (NPIX - 1)));
    run_row(16'hC000, 1'b0, "adjacent high");
    run_row(16'h0005, 1'b0, "gap two");
    run_row(16'hFFFF, 1'b0, "full");
    run_row(16'hA5A5, 1'b0, "alt");
    run_row(16'h1248, 1'b0, "sparse");
    for (int t = 0; t < 8; t++) run_row(NPIX'($urandom), 1'b0, "random");
  endtask

  task automatic test_busy_start();
    run_row(16'h0810, 1'b1, "poke");
  endtask

  task automatic test_hold();
    logic [NSLOT-1:0] exp = ref_mid(16'h0C30);
    run_row(16'h0C30, 1'b0, "hold base");
    for (int c = 0; c < 5; c++) begin
      row_i = NPIX'($urandom);
      @(negedge clk);
      check(mid_o === exp && busy_o === 1'b0, "R8 held while idle", 64'(mid_o), 64'(exp));
    end
  endtask

  initial begin
    test_reset();
    test_few_pixels();
    test_patterns();
    test_busy_start();
    test_hold();
    run_row(16'h0000, 1'b0, "reload clears");
    check(mid_o === '0, "R6 reload after nonzero", 64'(mid_o), 64'd0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule